// File: doc/BRIEF.md
# Mode-Dependent GPIO Port with Address Muxing

This block is an eight-pin general-purpose I/O port. Depending on the chip's operating mode, some or all of its pins can be taken over to carry the external address byte supplied by the bus controller. Software programs the port through a simple register bus that has an address, write and read strobes, and byte-wide write and read data. There are five locations: a write-only direction register, an output data latch, a read-only pin-state view, a pull-up enable register and an open-drain select register.

For each pin the block produces an output value, an output enable and a pull-up enable for the pad. The pad's electrical behaviour is outside the block. Two reset inputs act on the registers differently. A hardware standby input clears the direction register. A software standby input, together with a standby-output-enable control, decides whether address pins keep driving their last value or float.

Top module: `gpio_addr_port`

## Requirements
- R1: The direction register (offset 0xFE3B, bit i controls pin i) can be written but not read. A read of offset 0xFE3B returns 0xFF.
- R2: An active-low power-on reset clears the direction register, the data latch, the pull-up register and the open-drain register to 0x00. An active-low manual reset clears the data latch, the pull-up register and the open-drain register, but leaves the direction register unchanged.
- R3: While hardware standby is high, the direction register is cleared to 0x00 on each clock. Software standby leaves every register unchanged.
- R4: In modes 4 and 5 every pin drives the address input, with its output enable high, whatever the direction register holds.
- R5: In mode 6 a pin whose direction bit is 1 drives its address bit with output enable high. A pin whose direction bit is 0 is an input.
- R6: In mode 7 a pin whose direction bit is 1 drives its data latch bit with output enable high. A pin whose direction bit is 0 is an input. In modes 0 to 3 every pin is an input.
- R7: While software standby is high, address pins drive the address value captured on the last clock before standby began. The standby-output-enable input decides their output enable: 1 keeps it high, 0 drops it to 0. Leaving standby makes the pins follow the live address again.
- R8: A read of the pin-state view (offset 0xFFBB) returns, for input pins, the pad input after a two-flop synchronizer, and for all other pins the data latch bit.
- R9: A pin's pull-up enable is 1 only when the pin is an input and its bit in the pull-up register (offset 0xFE42) is 1.
- R10: On a mode-7 general output pin whose open-drain bit (offset 0xFE49) is 1, a latch value of 1 turns the output enable off and a latch value of 0 drives 0. The open-drain bit has no effect on address pins or input pins.
- R11: A write to the pin-state view is ignored and leaves all registers unchanged.
- R12: The data latch (offset 0xFF0B), the pull-up register and the open-drain register read back the last value written. Reads of other offsets, and any read with the read strobe low, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_man_n | input | 1 | Manual reset, active low, asynchronous |
| hw_stby | input | 1 | Hardware standby, clears the direction register |
| sw_stby | input | 1 | Software standby |
| stby_oe | input | 1 | Keep address pins driven during software standby |
| mode | input | 3 | Operating mode |
| bus_addr | input | 16 | Register address (lower 16 bits) |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| ext_addr | input | 8 | Address byte from the bus controller |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |

## Verification
The bench steps through all of the operating modes with mixed direction, latch, open-drain and pull-up patterns. It checks each pin's function separately, so a design that decodes the mode wrongly or mixes up the address and latch sources shows wrong bits on individual pins. It enters software standby and changes the address in the same cycle: a design that fails to freeze the captured value follows the new address, and one that ignores the standby-output-enable keeps driving pins that should float. Both reset classes and hardware standby are applied with the direction register set, so a design that clears or keeps the wrong registers shows it. A write to the read-only pin-state view that leaks into the latch changes the pad output.

// File: rtl/gpio_addr_port.sv
module gpio_addr_port #(
  parameter int W = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] OFS_DIR  = 16'hFE3B,
  parameter logic [AW-1:0] OFS_LAT  = 16'hFF0B,
  parameter logic [AW-1:0] OFS_PIN  = 16'hFFBB,
  parameter logic [AW-1:0] OFS_PULL = 16'hFE42,
  parameter logic [AW-1:0] OFS_OD   = 16'hFE49
) (
  input  logic          clk,
  input  logic          rst_por_n,
  input  logic          rst_man_n,
  input  logic          hw_stby,
  input  logic          sw_stby,
  input  logic          stby_oe,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  ext_addr,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pu
);

  logic [W-1:0] dir_q, lat_q, pull_q, od_q, meta_q, sync_q, ahold_q;

  wire wr_ok = bus_we && rst_man_n;

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n)                      dir_q <= '0;
    else if (hw_stby)                    dir_q <= '0;
    else if (wr_ok && bus_addr == OFS_DIR) dir_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_por_n or negedge rst_man_n) begin
    if (!rst_por_n || !rst_man_n) begin
      lat_q  <= '0;
      pull_q <= '0;
      od_q   <= '0;
    end else if (bus_we) begin
      if (bus_addr == OFS_LAT)  lat_q  <= bus_wdata;
      if (bus_addr == OFS_PULL) pull_q <= bus_wdata;
      if (bus_addr == OFS_OD)   od_q   <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n) begin
      meta_q  <= '0;
      sync_q  <= '0;
      ahold_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      if (!sw_stby) ahold_q <= ext_addr;
    end
  end

  wire all_addr = (mode == 3'd4) || (mode == 3'd5);
  wire m6 = (mode == 3'd6);
  wire m7 = (mode == 3'd7);

  wire [W-1:0] addr_pin = {W{all_addr}} | ({W{m6}} & dir_q);
  wire [W-1:0] gpo_pin  = {W{m7}} & dir_q;
  wire [W-1:0] in_pin   = ~(addr_pin | gpo_pin);
  wire [W-1:0] addr_val = sw_stby ? ahold_q : ext_addr;
  wire         addr_drv = !sw_stby || stby_oe;

  assign pad_out = (addr_pin & addr_val) | (gpo_pin & lat_q & ~od_q);
  assign pad_oe  = (addr_pin & {W{addr_drv}}) | (gpo_pin & ~(lat_q & od_q));
  assign pad_pu  = in_pin & pull_q;

  wire [W-1:0] pin_view = (in_pin & sync_q) | (~in_pin & lat_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      unique case (bus_addr)
        OFS_DIR:  bus_rdata = '1;
        OFS_LAT:  bus_rdata = lat_q;
        OFS_PIN:  bus_rdata = pin_view;
        OFS_PULL: bus_rdata = pull_q;
        OFS_OD:   bus_rdata = od_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R3
  hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    hw_stby |=> dir_q == '0);

  // R2
  man_keep_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    (!rst_man_n && !hw_stby) |=> $stable(dir_q));

  // R7
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    sw_stby |=> (!sw_stby || $stable(ahold_q)));

  // R11
  pin_wr_chk: assert property (@(posedge clk) disable iff (!rst_por_n || !rst_man_n)
    (bus_we && bus_addr == OFS_PIN && !hw_stby) |=>
      ($stable(lat_q) && $stable(pull_q) && $stable(od_q) && $stable(dir_q)));

  // R9
  pu_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    (pad_pu & pad_oe) == '0);

  // R4
  addr45_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    ((mode == 3'd4 || mode == 3'd5) && !sw_stby) |-> pad_oe == '1);

endmodule

// File: tb/gpio_addr_port_bench.sv
module gpio_addr_port_bench;
  localparam logic [15:0] A_DIR = 16'hFE3B, A_LAT = 16'hFF0B, A_PIN = 16'hFFBB,
                          A_PU = 16'hFE42, A_OD = 16'hFE49;

  logic clk = 0, rst_por_n = 0, rst_man_n = 1, hw_stby = 0, sw_stby = 0, stby_oe = 0;
  logic [2:0] mode = 3'd7;
  logic [15:0] bus_addr = '0;
  logic bus_we = 0, bus_re = 0;
  logic [7:0] bus_wdata = '0, ext_addr = '0, pad_in = '0;
  logic [7:0] bus_rdata, pad_out, pad_oe, pad_pu;
  int checks = 0, fails = 0;

  gpio_addr_port u_gpio_addr_port (
    .clk(clk), .rst_por_n(rst_por_n), .rst_man_n(rst_man_n), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .stby_oe(stby_oe), .mode(mode), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_addr(ext_addr), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu));

  always #10 clk = ~clk;

  // {mode, dir, lat, od, pu, ext_addr, pad_in, exp_out, exp_oe, exp_pu, exp_pinview}
  localparam logic [87:0] VEC [7] = '{
    {8'd7, 8'hF0, 8'hA5, 8'h00, 8'h0F, 8'h3C, 8'h5A, 8'hA0, 8'hF0, 8'h0F, 8'hAA},
    {8'd7, 8'hFF, 8'hC3, 8'h0F, 8'hFF, 8'h00, 8'h00, 8'hC0, 8'hFC, 8'h00, 8'hC3},
    {8'd6, 8'h33, 8'hFF, 8'hFF, 8'hFF, 8'h96, 8'hE1, 8'h12, 8'h33, 8'hCC, 8'hF3},
    {8'd4, 8'h00, 8'h12, 8'h00, 8'hFF, 8'h7E, 8'h81, 8'h7E, 8'hFF, 8'h00, 8'h12},
    {8'd5, 8'h0F, 8'h00, 8'hFF, 8'h00, 8'hA5, 8'hFF, 8'hA5, 8'hFF, 8'h00, 8'h00},
    {8'd7, 8'h00, 8'hFF, 8'h00, 8'hAA, 8'hFF, 8'h3C, 8'h00, 8'h00, 8'hAA, 8'h3C},
    {8'd2, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h99, 8'h00, 8'h00, 8'hFF, 8'h99}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_re = 1;
    #1 chk(bus_rdata, exp, tag);
    bus_re = 0;
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_por_n = 1;
    @(negedge clk);
    // R2 reset state
    rd(A_LAT, 8'h00, "R2 latch after por");
    rd(A_PU, 8'h00, "R2 pullup after por");
    rd(A_OD, 8'h00, "R2 opendrain after por");
    chk(pad_oe, 8'h00, "R2 oe after por");
    rd(A_DIR, 8'hFF, "R1 direction read");

    for (int i = 0; i < 7; i++) begin
      logic [87:0] v;
      string mt;
      v = VEC[i];
      mode = v[82:80];
      wr(A_DIR, v[79:72]); wr(A_LAT, v[71:64]); wr(A_OD, v[63:56]); wr(A_PU, v[55:48]);
      ext_addr = v[47:40]; pad_in = v[39:32];
      repeat (3) @(negedge clk);
      mt = (v[82:80] == 3'd4 || v[82:80] == 3'd5) ? "R4" : (v[82:80] == 3'd6) ? "R5" : "R6";
      if (i == 1) mt = "R10";
      chk(pad_out, v[31:24], $sformatf("%s out row%0d", mt, i));
      chk(pad_oe, v[23:16], $sformatf("%s oe row%0d", mt, i));
      chk(pad_pu, v[15:8], $sformatf("R9 pu row%0d", i));
      rd(A_PIN, v[7:0], $sformatf("R8 pinview row%0d", i));
      rd(A_LAT, v[71:64], $sformatf("R12 latch read row%0d", i));
      rd(A_OD, v[63:56], $sformatf("R12 od read row%0d", i));
      rd(A_DIR, 8'hFF, $sformatf("R1 dir read row%0d", i));
    end
    rd(16'h1234, 8'h00, "R12 unmapped read");

    // R10 open drain ignored on address pins
    mode = 3'd6; wr(A_DIR, 8'hFF); wr(A_OD, 8'hFF); wr(A_LAT, 8'hFF); ext_addr = 8'h5A;
    @(negedge clk);
    chk(pad_out, 8'h5A, "R10 od no effect on addr out");
    chk(pad_oe, 8'hFF, "R10 od no effect on addr oe");

    // R11 write to pin view ignored
    mode = 3'd7; wr(A_OD, 8'h00); wr(A_LAT, 8'h55);
    wr(A_PIN, 8'hAA);
    @(negedge clk);
    chk(pad_out, 8'h55, "R11 out after pin write");
    rd(A_LAT, 8'h55, "R11 latch after pin write");

    // R2 manual reset keeps direction, clears latch
    @(negedge clk); rst_man_n = 0;
    @(negedge clk); rst_man_n = 1;
    @(negedge clk);
    chk(pad_oe, 8'hFF, "R2 dir kept on manual reset");
    chk(pad_out, 8'h00, "R2 latch cleared on manual reset");

    // R7 software standby hold / float
    mode = 3'd6; stby_oe = 1; ext_addr = 8'h5A;
    repeat (2) @(negedge clk);
    sw_stby = 1; ext_addr = 8'hC3;
    repeat (2) @(negedge clk);
    chk(pad_out, 8'h5A, "R7 held address");
    chk(pad_oe, 8'hFF, "R7 oe kept");
    stby_oe = 0;
    #1 chk(pad_oe, 8'h00, "R7 oe floats");
    @(negedge clk); sw_stby = 0;
    #1 chk(pad_out, 8'hC3, "R7 live address after exit");
    chk(pad_oe, 8'hFF, "R3 dir kept through sw standby");

    // R3 hardware standby clears direction
    @(negedge clk); hw_stby = 1;
    @(negedge clk); hw_stby = 0;
    chk(pad_oe, 8'h00, "R3 dir cleared by hw standby");

    // R2 por clears direction
    wr(A_DIR, 8'hFF);
    chk(pad_oe, 8'hFF, "R5 dir set before por");
    rst_por_n = 0; #1;
    chk(pad_oe, 8'h00, "R2 dir cleared by por");
    @(negedge clk); rst_por_n = 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule